// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator with Serial Frequency Lock

This block produces the running phase of a video colour subcarrier. A 32-bit phase register advances every clock by a frequency increment. Downstream logic uses the top bits of the phase to address a sine/cosine table for the chroma modulator. In normal operation the increment comes from a programmed 32-bit frequency word, which is assembled from four byte registers elsewhere in the chip.

A single shared control pin can take one of two roles, chosen by a 2-bit mode input. In serial-lock mode, an external decoder sends a 67-bit frame on the pin at two clocks per bit. Part of each frame is a 22-bit frequency field. The block holds that field in a shadow register and moves it into the increment only at a line start, so the subcarrier tracks line-length variation one line at a time. In phase-reset mode, a rising edge on the pin arms a request, and the phase returns to zero at the next field start.

Top module: `subcarrier_nco`

## Requirements
- R1: While reset is asserted, `phase` and `tableIdx` read zero and the increment is zero, so the first value after reset release is also zero.
- R2: Each clock, `phase` becomes the previous `phase` plus the current increment, modulo 2^32, unless a phase clear applies.
- R3: Outside serial-lock mode, the increment takes the value `progFreq` had at the previous clock edge, so a change on `progFreq` alters the phase step one cycle later.
- R4: `tableIdx` always equals the top 10 bits of `phase`.
- R5: `pinMode` encoding: 2'b01 selects phase-reset, 2'b10 selects serial-lock, and 2'b00 and 2'b11 make the pin ignored. With the pin ignored, pin activity and `fieldStart` never clear the phase.
- R6: In serial-lock mode, a frame starts when the pin is seen high in cycle E after being low in the previous cycle. The block samples stream bit k in cycle E+3+2k, which is the second clock of that bit's window. The frame ends in cycle E+135, and the block looks for a new start only from cycle E+136 on.
- R7: Stream bits 0 to 21 form the frequency field with stream bit 0 as its most significant bit. The field is loaded into increment bits 31..10, and increment bits 9..0 are zero. Stream bits 22 to 66 are ignored.
- R8: In serial-lock mode, the increment changes only in a cycle where `lineStart` is high, and then it takes the field of the last completed frame. A frame that completes in the same cycle as `lineStart` is used at the next line start. Before any frame has completed, the field is zero. `progFreq` is ignored in this mode.
- R9: In phase-reset mode, a rising pin edge arms a request. At the first later cycle with `fieldStart` high, `phase` reads zero after that edge and then advances from zero.
- R10: A request is consumed by the field start that applies it. A field start with no request does not clear the phase. An edge that arrives in the same cycle as `fieldStart` is kept for the following field start. Leaving phase-reset mode drops any armed request.
- R11: A pin that is already high when reset is released is not treated as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pinMode | input | 2 | Role of the shared control pin |
| ctrlPin | input | 1 | Shared control pin: reset edge or serial frequency stream |
| lineStart | input | 1 | One-cycle pulse at the start of each video line |
| fieldStart | input | 1 | One-cycle pulse at the start of each field |
| progFreq | input | 32 | Programmed frequency word |
| phase | output | 32 | Subcarrier phase accumulator |
| tableIdx | output | 10 | Top phase bits used as the sine/cosine table address |

## Verification
Inputs are driven at the falling edge and take effect at the next rising edge. The new `phase` is compared at the following falling edge, one register stage after the stimulus. An increment change from `progFreq` or from a line-start load therefore shows up in the phase step of the comparison after that. A phase clear reads as zero at the falling edge right after the field-start cycle. The bench steps a requirement-level model once per rising edge and compares against it at every falling edge. It captures the shadow word only after the final clock of each frame it sends, so a line start in that final cycle is expected to use the older word.

// File: rtl/subcarrier_nco_pkg.sv
package subcarrier_nco_pkg;

  typedef enum logic [1:0] {
    PIN_IGNORE      = 2'b00,
    PIN_PHASE_RESET = 2'b01,
    PIN_SERIAL_FREQ = 2'b10,
    PIN_SPARE       = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic loadProg;
    logic loadSerial;
    logic zeroPhase;
  } nco_strobe_t;

endpackage

// File: rtl/subcarrier_nco_ctrl.sv
module subcarrier_nco_ctrl
  import subcarrier_nco_pkg::*;
#(
  parameter int FRAME_BITS = 67,
  parameter int BIT_CLKS   = 2,
  parameter int FIELD_LO   = 0,
  parameter int FIELD_HI   = 21,
  localparam int FW        = FIELD_HI - FIELD_LO + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pinMode,
  input  logic          ctrlPin,
  input  logic          lineStart,
  input  logic          fieldStart,
  output nco_strobe_t   st,
  output logic [FW-1:0] rtcWord
);

  localparam int BIT_IDX_W = $clog2(FRAME_BITS + 1);
  localparam int SUB_W     = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [SUB_W-1:0]     SUB_LAST = SUB_W'(BIT_CLKS - 1);
  localparam logic [SUB_W-1:0]     SUB_MID  = SUB_W'(BIT_CLKS / 2);
  localparam logic [BIT_IDX_W-1:0] IDX_LAST = BIT_IDX_W'(FRAME_BITS);
  localparam logic [BIT_IDX_W-1:0] IDX_LO   = BIT_IDX_W'(FIELD_LO);
  localparam logic [BIT_IDX_W-1:0] IDX_HI   = BIT_IDX_W'(FIELD_HI + 1);

  pin_mode_e mode;
  logic isReset, isSerial;
  logic pinPrev, riseEdge;
  logic pending;
  logic busy;
  logic [SUB_W-1:0]     subCnt;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [FW-1:0]        capReg, shadowWord;
  logic sampleNow, inField, frameDone;

  assign mode     = pin_mode_e'(pinMode);
  assign isReset  = (mode == PIN_PHASE_RESET);
  assign isSerial = (mode == PIN_SERIAL_FREQ);
  assign riseEdge = ctrlPin & ~pinPrev;

  // bitIdx 0 is the start bit; data bit k sits at bitIdx k+1
  assign inField   = (bitIdx > IDX_LO) && (bitIdx <= IDX_HI);
  assign sampleNow = busy && (bitIdx != '0) && (subCnt == SUB_MID);
  assign frameDone = busy && (bitIdx == IDX_LAST) && (subCnt == SUB_LAST);

  // pin history; reset high so a pin held high at release is no edge
  always_ff @(posedge clk) begin
    if (!rst_n) pinPrev <= 1'b1;
    else        pinPrev <= ctrlPin;
  end

  // field-aligned phase clear request
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= isReset & (riseEdge | (pending & ~fieldStart));
  end

  // serial frame receiver
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      subCnt     <= '0;
      bitIdx     <= '0;
      capReg     <= '0;
      shadowWord <= '0;
    end else if (!isSerial) begin
      busy   <= 1'b0;
      subCnt <= '0;
      bitIdx <= '0;
    end else if (!busy) begin
      if (riseEdge) begin
        busy   <= 1'b1;
        subCnt <= SUB_W'(1);
        bitIdx <= '0;
      end
    end else begin
      if (sampleNow && inField) capReg <= {capReg[FW-2:0], ctrlPin};
      if (frameDone) begin
        busy       <= 1'b0;
        subCnt     <= '0;
        bitIdx     <= '0;
        shadowWord <= capReg;
      end else if (subCnt == SUB_LAST) begin
        subCnt <= '0;
        bitIdx <= bitIdx + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  assign st.loadProg   = ~isSerial;
  assign st.loadSerial = isSerial & lineStart;
  assign st.zeroPhase  = isReset & pending & fieldStart;
  assign rtcWord       = shadowWord;

  // R6
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitIdx <= IDX_LAST);

  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isReset && pending && fieldStart && !riseEdge) |=> !pending);

endmodule

// File: rtl/subcarrier_nco_path.sv
module subcarrier_nco_path
  import subcarrier_nco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int TABLE_W = 10,
  parameter int FW      = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  nco_strobe_t        st,
  input  logic [PHASE_W-1:0] progFreq,
  input  logic [FW-1:0]      rtcWord,
  output logic [PHASE_W-1:0] phase,
  output logic [TABLE_W-1:0] tableIdx
);

  localparam int PAD_W = PHASE_W - FW;

  logic [PHASE_W-1:0] incr;
  logic pastValid;

  always_ff @(posedge clk) begin
    if (!rst_n)             incr <= '0;
    else if (st.loadProg)   incr <= progFreq;
    else if (st.loadSerial) incr <= {rtcWord, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            phase <= '0;
    else if (st.zeroPhase) phase <= '0;
    else                   phase <= phase + incr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  assign tableIdx = phase[PHASE_W-1 -: TABLE_W];

  // R2
  accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && !$past(st.zeroPhase)) |-> phase == PHASE_W'($past(phase) + $past(incr)));

  // R9
  zero_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(st.zeroPhase)) |-> phase == '0);

  // R8
  incr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(!st.loadProg && !st.loadSerial)) |-> incr == $past(incr));

endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
  import subcarrier_nco_pkg::*;
#(
  parameter int PHASE_W    = 32,
  parameter int TABLE_W    = 10,
  parameter int FRAME_BITS = 67,
  parameter int BIT_CLKS   = 2,
  parameter int FIELD_LO   = 0,
  parameter int FIELD_HI   = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pinMode,
  input  logic               ctrlPin,
  input  logic               lineStart,
  input  logic               fieldStart,
  input  logic [PHASE_W-1:0] progFreq,
  output logic [PHASE_W-1:0] phase,
  output logic [TABLE_W-1:0] tableIdx
);

  localparam int FW = FIELD_HI - FIELD_LO + 1;

  nco_strobe_t   st;
  logic [FW-1:0] rtcWord;

  subcarrier_nco_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .BIT_CLKS  (BIT_CLKS),
    .FIELD_LO  (FIELD_LO),
    .FIELD_HI  (FIELD_HI)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pinMode   (pinMode),
    .ctrlPin   (ctrlPin),
    .lineStart (lineStart),
    .fieldStart(fieldStart),
    .st        (st),
    .rtcWord   (rtcWord)
  );

  subcarrier_nco_path #(
    .PHASE_W(PHASE_W),
    .TABLE_W(TABLE_W),
    .FW     (FW)
  ) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .progFreq(progFreq),
    .rtcWord (rtcWord),
    .phase   (phase),
    .tableIdx(tableIdx)
  );

endmodule

// File: tb/subcarrier_nco_bench.sv
module subcarrier_nco_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PW    = 32;
  localparam int TW    = 10;
  localparam int FW    = 22;
  localparam int NBITS = 67;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pinMode = 2'b01;
  logic ctrlPin = 1'b1;
  logic lineStart = 1'b0;
  logic fieldStart = 1'b0;
  logic [PW-1:0] progFreq = 32'h0123_4567;
  logic [PW-1:0] phase;
  logic [TW-1:0] tableIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  subcarrier_nco u_subcarrier_nco (
    .clk(clk), .rst_n(rst_n), .pinMode(pinMode), .ctrlPin(ctrlPin),
    .lineStart(lineStart), .fieldStart(fieldStart), .progFreq(progFreq),
    .phase(phase), .tableIdx(tableIdx)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // requirement-level model state
  logic [PW-1:0] mPhase = '0;
  logic [PW-1:0] mIncr = '0;
  logic          mPrev = 1'b1;
  logic          mPend = 1'b0;
  logic [FW-1:0] mShadow = '0;

  task automatic chk(input bit ok, input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs already driven; model the edge, compare at the falling edge
  task automatic step(input string tag);
    logic edgeSeen;
    logic [PW-1:0] nPhase, nIncr;
    @(posedge clk);
    edgeSeen = ctrlPin && !mPrev;
    nPhase = (pinMode == 2'b01 && mPend && fieldStart) ? '0 : mPhase + mIncr;
    nIncr  = (pinMode == 2'b10) ? (lineStart ? {mShadow, 10'b0} : mIncr) : progFreq;
    mPend  = (pinMode == 2'b01) && (edgeSeen || (mPend && !fieldStart));
    mPrev  = ctrlPin;
    mPhase = nPhase;
    mIncr  = nIncr;
    @(negedge clk);
    chk(phase === mPhase, tag, phase, mPhase);
    chk(tableIdx === mPhase[PW-1 -: TW], "R4", {22'b0, tableIdx}, {22'b0, mPhase[PW-1 -: TW]});
  endtask

  task automatic sendFrame(input logic [FW-1:0] word, input string tag, input bit flipFirst, input bit lineOnLast);
    ctrlPin = 1'b0; lineStart = 1'b0;
    step(tag);
    for (int s = 0; s < 2; s++) begin
      ctrlPin = 1'b1; lineStart = ($urandom % 12 == 0); progFreq = $urandom;
      step(tag);
    end
    for (int k = 0; k < NBITS; k++) begin
      logic b;
      b = (k < FW) ? word[FW-1-k] : 1'($urandom);
      for (int h = 0; h < 2; h++) begin
        ctrlPin   = (flipFirst && h == 0) ? ~b : b;
        lineStart = (k == NBITS-1 && h == 1) ? lineOnLast : ($urandom % 12 == 0);
        progFreq  = $urandom;
        step(tag);
      end
    end
    mShadow = word;
    ctrlPin = 1'b0; lineStart = 1'b0;
  endtask

  initial begin
    logic [PW-1:0] p0;
    logic [FW-1:0] w1, w2;
    void'($urandom(32'd7741));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(phase === '0, "R1", phase, '0);
    chk(tableIdx === '0, "R1", {22'b0, tableIdx}, '0);
    rst_n = 1'b1;
    step("R1");
    chk(phase === '0, "R1", phase, '0);

    // R11: pin high through reset release is no edge
    repeat (3) step("R11");
    fieldStart = 1'b1; step("R11"); fieldStart = 1'b0;
    chk(phase !== '0, "R11", phase, 32'h1);

    // R2 / R3: programmed word, wrap, one-cycle latency
    pinMode = 2'b00;
    progFreq = 32'h0000_1000; step("R3");
    progFreq = 32'h0000_2000; step("R3");
    p0 = phase; step("R3");
    chk(phase - p0 === 32'h0000_2000, "R3", phase - p0, 32'h0000_2000);
    for (int i = 0; i < 300; i++) begin
      progFreq   = (i % 40 < 5) ? 32'hFFFF_FF00 + i : $urandom;
      lineStart  = ($urandom % 8 == 0);
      step("R2");
    end
    lineStart = 1'b0;

    // R5: pin ignored in modes 00 and 11
    for (int i = 0; i < 200; i++) begin
      pinMode    = (i < 100) ? 2'b00 : 2'b11;
      ctrlPin    = 1'($urandom);
      fieldStart = ($urandom % 5 == 0);
      progFreq   = 32'h0400_0000 + i;
      step("R5");
      chk(phase !== '0, "R5", phase, 32'h1);
    end
    fieldStart = 1'b0;

    // R9: armed clear applied at next field start
    pinMode = 2'b01; progFreq = 32'h0001_0000; ctrlPin = 1'b0;
    step("R9");
    ctrlPin = 1'b1; step("R9");
    repeat (5) step("R9");
    chk(phase !== '0, "R9", phase, 32'h1);
    fieldStart = 1'b1; step("R9"); fieldStart = 1'b0;
    chk(phase === '0, "R9", phase, '0);
    step("R9");
    chk(phase === 32'h0001_0000, "R9", phase, 32'h0001_0000);

    // R10: consumed, same-cycle edge kept, mode exit drops request
    fieldStart = 1'b1; step("R10"); fieldStart = 1'b0;
    chk(phase !== '0, "R10", phase, 32'h1);
    ctrlPin = 1'b0; step("R10");
    ctrlPin = 1'b1; fieldStart = 1'b1; step("R10");
    chk(phase !== '0, "R10", phase, 32'h1);
    fieldStart = 1'b0; step("R10");
    fieldStart = 1'b1; step("R10"); fieldStart = 1'b0;
    chk(phase === '0, "R10", phase, '0);
    ctrlPin = 1'b0; step("R10");
    ctrlPin = 1'b1; step("R10");
    pinMode = 2'b00; step("R10");
    pinMode = 2'b01; fieldStart = 1'b1; step("R10"); fieldStart = 1'b0;
    chk(phase !== '0, "R10", phase, 32'h1);

    // R9: random pin and field activity in phase-reset mode
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0) ctrlPin = ~ctrlPin;
      fieldStart = ($urandom % 25 == 0);
      progFreq   = $urandom;
      step("R9");
    end
    fieldStart = 1'b0;

    // R8: serial mode before any frame loads a zero word
    pinMode = 2'b10; ctrlPin = 1'b0; progFreq = $urandom;
    step("R8");
    lineStart = 1'b1; step("R8"); lineStart = 1'b0;
    step("R8");
    p0 = phase; progFreq = $urandom; step("R8");
    chk(phase === p0, "R8", phase, p0);

    // R7: field bit mapping, loaded at a line start
    w1 = 22'h2A_5C3;
    sendFrame(w1, "R7", 1'b0, 1'b0);
    lineStart = 1'b1; step("R7"); lineStart = 1'b0;
    step("R7");
    p0 = phase; step("R7");
    chk(phase - p0 === {w1, 10'b0}, "R7", phase - p0, {w1, 10'b0});

    // R6 and R8: mid-window sampling; line start in the final frame cycle keeps old word
    w2 = 22'h15_A3C;
    sendFrame(w2, "R6", 1'b1, 1'b1);
    step("R8");
    p0 = phase; step("R8");
    chk(phase - p0 === {w1, 10'b0}, "R8", phase - p0, {w1, 10'b0});
    lineStart = 1'b1; step("R6"); lineStart = 1'b0;
    step("R6");
    p0 = phase; step("R6");
    chk(phase - p0 === {w2, 10'b0}, "R6", phase - p0, {w2, 10'b0});

    // R6: random frames with random line starts
    for (int f = 0; f < 6; f++) begin
      sendFrame(22'($urandom), "R6", 1'(f % 2), 1'($urandom));
      for (int i = 0; i < 5; i++) begin
        lineStart = (i == 2);
        step("R8");
      end
    end
    lineStart = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule